// File: doc/BRIEF.md
# Per-Core Private Countdown Timer

This block is a 32-bit down-counting timer with one interrupt line, placed once beside each processor core. Software reaches it through a simple word-wide register port: a start value, the live count, a control word and a sticky event flag. While enabled and holding a nonzero count, the counter steps down once every (prescale + 1) clocks. When it runs out it raises the event flag. It then either reloads from the start value and keeps running, or parks at zero.

The register port takes a word index and a select with a write strobe. Writes take effect on the clock edge. Read data is combinational from the current state. The interrupt line is a registered copy of "flag set and interrupt enabled".

Top module: `pcore_timer`

## Requirements
- R1: After reset the start value, count, control word and event flag all read as zero, and the interrupt output is low.
- R2: Word index 0 holds the start value, index 1 the count, index 2 the control word and index 3 the status word. Indices 4 to 7 read as zero, and writes to them change nothing.
- R3: Control bit 0 enables counting, bit 1 selects auto-reload, bit 2 enables the interrupt, and bits 15:8 hold the prescale value. A control read returns exactly these fields, with every other bit zero.
- R4: While the timer is running, the count drops by one every (prescale + 1) clocks, counted from the last restart.
- R5: A write to index 0 stores the start value and copies it into the count in the same edge. If the timer is enabled, prescaling restarts from that point.
- R6: A write to index 1 sets the count directly and restarts prescaling. The timer then counts down from that value once it is enabled.
- R7: On a tick at count 1, status bit 0 is set in that same edge. With auto-reload on, the count takes the start value and counting carries on.
- R8: On a tick at count 1 with auto-reload off, the count becomes zero and counting stops.
- R9: The interrupt output rises one clock after the flag and interrupt enable are both set, and it is low otherwise.
- R10: Writing status with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag unchanged. An expiry in the same cycle as a clear wins.
- R11: A control write that sets enable while the timer is enabled with a nonzero count leaves the count alone. When enable goes from 0 to 1 with auto-reload set, the count is first loaded from the start value.
- R12: Reading index 1 returns zero while enable is clear. Clearing enable freezes the count.
- R13: A count of zero never produces an expiry, even with enable and auto-reload set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, valid with select |
| bus_waddr_i | input | ADDR_W-2 | Word index inside the register window |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for the addressed word |
| irq_o | output | 1 | Registered timer interrupt |

## Verification
The hardest situations to reach are those where a register write lands while the counter is moving. Examples are a second enable arriving mid-count, a start-value write during a prescaled wait, and a status clear in the cycle the flag is set again. The stimulus reaches them by setting a long prescale and short counts, then issuing writes at several offsets into a running period. A behavioural model in the bench follows every clock and is compared on each cycle, so any slip in reload or tick phase shows up at once.

// File: rtl/pcore_timer_pkg.sv
package pcore_timer_pkg;
  // word index of each register inside the window
  typedef enum logic [1:0] {
    IDX_START  = 2'd0,
    IDX_COUNT  = 2'd1,
    IDX_CTRL   = 2'd2,
    IDX_STATUS = 2'd3
  } reg_idx_e;

  // control word bit positions
  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_AR_BIT  = 1;
  localparam int unsigned CTL_IE_BIT  = 2;
  localparam int unsigned CTL_PSC_LSB = 8;
endpackage

// File: rtl/pcore_tmr_prescale.sv
module pcore_tmr_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;

  function automatic logic period_done(input logic [PSC_W-1:0] c, input logic [PSC_W-1:0] p);
    return c >= p;
  endfunction

  assign tick_o = run_i && !restart_i && period_done(div_q, psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          div_q <= '0;
    else if (!run_i || restart_i || tick_o) div_q <= '0;
    else                                  div_q <= div_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && psc_i != '0) |=> (!tick_o || psc_i == '0)); // R4
endmodule

// File: rtl/pcore_tmr_count.sv
module pcore_tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             autold_i,
  input  logic             set_i,
  input  logic [CNT_W-1:0] set_val_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] cur,
                                                 input logic ar,
                                                 input logic [CNT_W-1:0] ld);
    if (cur == CNT_W'(1)) return ar ? ld : '0;
    return cur - 1'b1;
  endfunction

  assign expire_o = tick_i && (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (set_i)    cnt_q <= set_val_i;
    else if (reload_i) cnt_q <= load_val_i;
    else if (tick_i)   cnt_q <= step_down(cnt_q, autold_i, load_val_i);
  end

  AST_AUTO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && autold_i) |=> (cnt_q == $past(load_val_i))); // R7
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !autold_i) |=> (cnt_q == '0)); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !set_i && !reload_i) |=> $stable(cnt_q)); // R12
endmodule

// File: rtl/pcore_tmr_regs.sv
module pcore_tmr_regs
  import pcore_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-3:0] bus_waddr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output logic [CNT_W-1:0]  load_o,
  output logic              en_o,
  output logic              autold_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic              set_o,
  output logic [CNT_W-1:0]  set_val_o,
  output logic              reload_o,
  output logic              restart_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  bus_rdata_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [CNT_W-1:0] load_q;
  logic [PSC_W-1:0] psc_q;
  logic en_q, ar_q, ie_q, flag_q, irq_q;

  logic wr_w, wr_start, wr_count, wr_ctrl, wr_stat, running_w, start_w;

  function automatic logic [CNT_W-1:0] ctrl_word(input logic en, input logic ar,
                                                 input logic ie, input logic [PSC_W-1:0] p);
    logic [CNT_W-1:0] w;
    w = '0;
    w[CTL_EN_BIT] = en;
    w[CTL_AR_BIT] = ar;
    w[CTL_IE_BIT] = ie;
    w[CTL_PSC_LSB +: PSC_W] = p;
    return w;
  endfunction

  assign wr_w      = bus_sel_i && bus_wr_i;
  assign wr_start  = wr_w && (bus_waddr_i == IDX_W'(IDX_START));
  assign wr_count  = wr_w && (bus_waddr_i == IDX_W'(IDX_COUNT));
  assign wr_ctrl   = wr_w && (bus_waddr_i == IDX_W'(IDX_CTRL));
  assign wr_stat   = wr_w && (bus_waddr_i == IDX_W'(IDX_STATUS));
  assign running_w = en_q && (cnt_i != '0);
  assign start_w   = wr_ctrl && bus_wdata_i[CTL_EN_BIT] && !running_w;

  assign set_o     = wr_start || wr_count;
  assign set_val_o = bus_wdata_i;
  assign reload_o  = start_w && bus_wdata_i[CTL_AR_BIT];
  assign restart_o = set_o || start_w;
  assign load_o    = load_q;
  assign en_o      = en_q;
  assign autold_o  = ar_q;
  assign psc_o     = psc_q;
  assign irq_o     = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      en_q   <= 1'b0;
      ar_q   <= 1'b0;
      ie_q   <= 1'b0;
      psc_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_start) load_q <= bus_wdata_i;
      if (wr_ctrl) begin
        en_q  <= bus_wdata_i[CTL_EN_BIT];
        ar_q  <= bus_wdata_i[CTL_AR_BIT];
        ie_q  <= bus_wdata_i[CTL_IE_BIT];
        psc_q <= bus_wdata_i[CTL_PSC_LSB +: PSC_W];
      end
      if (expire_i)                        flag_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[0])  flag_q <= 1'b0;
      irq_q <= flag_q && ie_q;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_waddr_i)
      IDX_W'(IDX_START):  bus_rdata_o = load_q;
      IDX_W'(IDX_COUNT):  bus_rdata_o = en_q ? cnt_i : '0;
      IDX_W'(IDX_CTRL):   bus_rdata_o = ctrl_word(en_q, ar_q, ie_q, psc_q);
      IDX_W'(IDX_STATUS): bus_rdata_o = {{(CNT_W-1){1'b0}}, flag_q};
      default:            bus_rdata_o = '0;
    endcase
  end

  AST_EXPIRE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_q); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_stat && bus_wdata_i[0])) |=> flag_q); // R10
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> ($past(flag_q) && $past(ie_q))); // R9
  AST_RUNNING_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && running_w && bus_wdata_i[CTL_EN_BIT]) |-> !reload_o); // R11
endmodule

// File: rtl/pcore_timer.sv
module pcore_timer #(
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-3:0] bus_waddr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_w, load_w, set_val_w;
  logic [PSC_W-1:0] psc_w;
  logic en_w, ar_w, set_w, reload_w, restart_w, tick_w, expire_w, run_w;

  assign run_w = en_w && (cnt_w != '0);

  pcore_tmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) regs_i (
    .clk_i, .rst_ni, .bus_sel_i, .bus_wr_i, .bus_waddr_i, .bus_wdata_i,
    .cnt_i(cnt_w), .expire_i(expire_w), .load_o(load_w), .en_o(en_w),
    .autold_o(ar_w), .psc_o(psc_w), .set_o(set_w), .set_val_o(set_val_w),
    .reload_o(reload_w), .restart_o(restart_w), .irq_o, .bus_rdata_o
  );

  pcore_tmr_prescale #(.PSC_W(PSC_W)) pre_i (
    .clk_i, .rst_ni, .run_i(run_w), .restart_i(restart_w), .psc_i(psc_w),
    .tick_o(tick_w)
  );

  pcore_tmr_count #(.CNT_W(CNT_W)) cnt_i (
    .clk_i, .rst_ni, .tick_i(tick_w), .autold_i(ar_w), .set_i(set_w),
    .set_val_i(set_val_w), .reload_i(reload_w), .load_val_i(load_w),
    .expire_o(expire_w), .cnt_o(cnt_w)
  );

  AST_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w == '0) |-> !tick_w); // R13
endmodule

// File: tb/pcore_timer_tb_top.sv
module pcore_timer_tb_top;
  localparam int CLK_P = 10;
  localparam int Q     = CLK_P / 4;
  localparam int WD_CYC = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pcore_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
    .bus_waddr_i(bus_waddr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq)
  );

  // behavioural reference model
  logic [31:0] m_start = '0, m_cnt = '0;
  int m_psc = 0, m_pre = 0;
  bit m_en = 0, m_ar = 0, m_ie = 0, m_flag = 0, m_irq = 0;

  always @(posedge clk) begin : model
    bit w, ws, wc, wt, wst, busy, go, tk, nirq;
    logic [31:0] ncnt;
    if (!rst_n) begin
      m_start = '0; m_cnt = '0; m_psc = 0; m_pre = 0;
      m_en = 0; m_ar = 0; m_ie = 0; m_flag = 0; m_irq = 0;
    end else begin
      w   = bus_sel && bus_wr;
      ws  = w && bus_waddr == 3'd0;
      wc  = w && bus_waddr == 3'd1;
      wt  = w && bus_waddr == 3'd2;
      wst = w && bus_waddr == 3'd3;
      busy = m_en && m_cnt != 0;
      go   = wt && bus_wdata[0] && !busy;
      tk   = busy && !(ws || wc || go) && (m_pre >= m_psc);
      nirq = m_flag && m_ie;
      if (!busy || ws || wc || go || tk) m_pre = 0; else m_pre = m_pre + 1;
      ncnt = m_cnt;
      if (ws || wc) ncnt = bus_wdata;
      else if (go && bus_wdata[1]) ncnt = m_start;
      else if (tk) ncnt = (m_cnt == 1) ? (m_ar ? m_start : 32'd0) : m_cnt - 1;
      if (tk && m_cnt == 1) m_flag = 1;
      else if (wst && bus_wdata[0]) m_flag = 0;
      if (ws) m_start = bus_wdata;
      if (wt) begin
        m_en = bus_wdata[0]; m_ar = bus_wdata[1]; m_ie = bus_wdata[2];
        m_psc = int'(bus_wdata[15:8]);
      end
      m_cnt = ncnt;
      m_irq = nirq;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_start;
      3'd1: return m_en ? m_cnt : 32'd0;
      3'd2: return {16'd0, 8'(m_psc), 5'd0, m_ie, m_ar, m_en};
      3'd3: return {31'd0, m_flag};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R5";
      3'd1: return "R12";
      3'd2: return "R3";
      3'd3: return "R10";
      default: return "R2";
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R9 irq", {31'd0, irq}, {31'd0, m_irq});
      check(tag_of(bus_waddr), bus_rdata, m_read(bus_waddr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #(Q);
    bus_sel = 1; bus_wr = 1; bus_waddr = a; bus_wdata = d;
    @(posedge clk); #(Q);
    bus_sel = 0; bus_wr = 0; bus_wdata = 32'hDEAD_BEEF;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #(Q);
  endtask

  // read a word against the model, tagged with a requirement
  task automatic look(input string tag, input logic [2:0] a);
    @(posedge clk); #(Q);
    bus_waddr = a;
    #(Q);
    check(tag, bus_rdata, m_read(a));
  endtask

  // read a word against a fixed value
  task automatic hard(input string tag, input logic [2:0] a, input logic [31:0] e);
    @(posedge clk); #(Q);
    bus_waddr = a;
    #(Q);
    check(tag, bus_rdata, e);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(Q); rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 4; a++) hard("R1", 3'(a), 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    cmp_on = 1;

    // R5 start value copies into count; R12 disabled count reads zero
    wr(3'd0, 32'd5);
    hard("R5", 3'd0, 32'd5);
    hard("R12", 3'd1, 32'd0);
    // enable one-shot with interrupt, prescale 0
    wr(3'd2, 32'h0000_0005);
    hard("R3", 3'd2, 32'h0000_0005);
    idle(10);
    hard("R7", 3'd3, 32'd1);
    hard("R8", 3'd1, 32'd0);
    check("R9", {31'd0, irq}, 32'd1);

    // R10 write 0 keeps flag, write 1 clears it
    wr(3'd3, 32'hFFFF_FFFE);
    hard("R10", 3'd3, 32'd1);
    wr(3'd3, 32'd1);
    hard("R10", 3'd3, 32'd0);
    idle(2);
    check("R9", {31'd0, irq}, 32'd0);

    // R11 re-enable with auto-reload from zero count loads start value
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd0);
    wr(3'd2, 32'h0000_0000);
    wr(3'd0, 32'd3);
    wr(3'd2, 32'h0000_0307);
    look("R11", 3'd1);
    idle(3);
    look("R4", 3'd1);
    idle(5);
    look("R4", 3'd1);
    idle(20);
    look("R7", 3'd1);
    look("R7", 3'd3);
    // R11 enable again while running: no disturbance
    idle(2);
    wr(3'd2, 32'h0000_0307);
    look("R11", 3'd1);
    idle(1);
    look("R11", 3'd1);
    // clear racing with an expiry
    for (int k = 0; k < 16; k++) begin
      wr(3'd3, 32'd1);
      look("R10", 3'd3);
    end

    // R5 start-value write during a prescaled wait
    idle(2);
    wr(3'd0, 32'd7);
    hard("R5", 3'd1, 32'd7);
    idle(3);
    look("R4", 3'd1);

    // R6 direct count write
    wr(3'd1, 32'd10);
    hard("R6", 3'd1, 32'd10);
    // R12 disable freezes and hides the count
    wr(3'd2, 32'h0000_0300);
    hard("R12", 3'd1, 32'd0);
    idle(12);
    wr(3'd2, 32'h0000_0201);
    look("R12", 3'd1);
    idle(40);
    look("R8", 3'd1);
    look("R8", 3'd3);

    // R13 zero count never expires
    wr(3'd3, 32'd1);
    wr(3'd0, 32'd0);
    wr(3'd2, 32'h0000_0007);
    idle(20);
    hard("R13", 3'd3, 32'd0);
    check("R13 irq", {31'd0, irq}, 32'd0);

    // R2 unmapped words read zero and ignore writes
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    hard("R2", 3'd5, 32'd0);
    hard("R2", 3'd0, 32'd0);
    hard("R2", 3'd2, 32'h0000_0007);
    look("R2", 3'd3);

    // R3 control fields round-trip, upper bits dropped
    wr(3'd2, 32'hFFFF_AAF8);
    hard("R3", 3'd2, 32'h0000_AA00);

    // auto-reload, small prescale, long run
    wr(3'd0, 32'd4);
    wr(3'd2, 32'h0000_0107);
    for (int k = 0; k < 30; k++) begin
      idle(3);
      look("R7", 3'd1);
    end

    idle(4);
    done = 1;
    finish_up();
  end
endmodule